// File: doc/BRIEF.md
# Power-of-Two Region Memory Protection Checker

This block holds a parameterised set of protection regions and decides whether a memory access may go ahead. Each region owns an 8-bit configuration entry and one address register. Software reaches both through a simple CSR read/write port. Configuration entries are packed four to a 32-bit CSR. The only supported region shape is a naturally aligned power-of-two window, and the smallest window is 8 bytes. A region can also be switched off.

An access is presented with its byte address, its kind (read, write or instruction fetch) and a user/machine privilege flag. One cycle later the block returns a fault flag. The lowest-numbered enabled region that covers the address decides the outcome. User code is denied everywhere no region covers it. Machine code is held only to regions that software has locked. A locked region cannot be changed again until reset. CSR addresses for regions above the configured count read back zero and drop writes without any error.

Top module: `pmp_napot_checker`

## Requirements
- R1: After reset every configuration entry reads zero, every region is off, and the result-valid output is low.
- R2: Region r has its configuration byte in bits 8*(r mod 4)+7 down to 8*(r mod 4) of the configuration CSR at CFG_BASE + r/4. Within that byte, bit 7 is lock, bits 4:3 are the mode (00 off, 11 power-of-two window), bit 2 is execute, bit 1 is write and bit 0 is read. Bits 6:5 always read zero.
- R3: A write that asks for mode 01 or 10 keeps the previous mode of that entry, while the other fields of the byte are still written.
- R4: Once the lock bit of a region is set, writes to that region's configuration byte and to its address register are ignored until reset. The lock bit itself cannot be cleared by software.
- R5: Region r's address register sits at ADDR_BASE + r. It holds bits 33:2 of the window address and reads back what was written. Any low bits implied by a granularity above 8 bytes are forced to one.
- R6: Configuration bytes and address CSRs of regions numbered NUM_REGIONS or above read zero, and writes to them have no effect.
- R7: An address register with t trailing one bits describes a 2^(t+3)-byte window aligned to its size. An access matches when its word address equals the register on every bit above bit t. An all-ones register covers the whole space.
- R8: When several enabled regions match, the one with the lowest index alone decides the permission.
- R9: A user access faults when no region matches. Otherwise it faults when the winning region lacks the bit for its kind. Kind code 00 is read, 01 is write and 10 is fetch; code 11 is never permitted.
- R10: A machine access faults only when the winning region is locked and lacks the permission for its kind. A machine access that matches nothing, or whose winning region is unlocked, does not fault.
- R11: The result is registered: res_valid is high exactly in the cycle after chk_valid, and res_fault carries the decision for that access.
- R12: A region whose mode is off never matches, whatever its address and permission bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (combinational from csr_addr) |
| chk_valid | input | 1 | Access to check is present |
| chk_addr | input | ADDR_W | Byte address of the access |
| chk_acc | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| chk_user | input | 1 | 1 for user privilege, 0 for machine |
| res_valid | output | 1 | Decision is present (one cycle after chk_valid) |
| res_fault | output | 1 | 1 when the access must be refused |

## Verification
Matching is tried with an 8-byte window probed inside it and one byte past each edge, a 64-byte window nested in a 4 KB window, and an all-ones register that covers everything. Together these separate a wrong trailing-ones count from a wrong compare or a missing mask. Overlapping windows with different permissions are probed in both the nested part and the outer part, so a priority order that runs the wrong way gives a different fault. The same addresses are also issued as user and as machine accesses, against locked and unlocked regions, which separates the user rule from the lock rule. Configuration writes carry reserved bits, illegal mode codes and lock-clearing attempts, and read-back shows whether each was filtered.

// File: rtl/pmp_napot_pkg.sv
package pmp_napot_pkg;

    localparam int CSR_W           = 32;
    localparam int ENTRY_W         = 8;
    localparam int ENTRIES_PER_CSR = CSR_W / ENTRY_W;
    localparam int MAX_CFG_CSRS    = 16;
    localparam int MAX_ADDR_CSRS   = 64;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_RSV_A = 2'b01,
        MODE_RSV_B = 2'b10,
        MODE_POW2  = 2'b11
    } win_mode_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_NONE  = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic      locked;
        logic [1:0] zero_f;
        win_mode_e mode;
        logic      perm_x;
        logic      perm_w;
        logic      perm_r;
    } region_cfg_t;

    // Fold a software byte into an entry: reserved bits cleared,
    // unsupported mode requests keep the previous mode.
    function automatic region_cfg_t cfg_merge(region_cfg_t prev, logic [ENTRY_W-1:0] wbyte);
        region_cfg_t nxt;
        nxt        = region_cfg_t'(wbyte);
        nxt.zero_f = 2'b00;
        if (nxt.mode == MODE_RSV_A || nxt.mode == MODE_RSV_B)
            nxt.mode = prev.mode;
        return nxt;
    endfunction

    function automatic logic cfg_permits(region_cfg_t c, acc_kind_e k);
        logic ok;
        unique case (k)
            ACC_READ:  ok = c.perm_r;
            ACC_WRITE: ok = c.perm_w;
            ACC_FETCH: ok = c.perm_x;
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/pmp_region_slot.sv
module pmp_region_slot
    import pmp_napot_pkg::*;
#(
    parameter int              AW         = 32,
    parameter logic [AW-1:0]   FORCE_MASK = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [ENTRY_W-1:0]  cfg_wbyte,
    input  logic                addr_wr,
    input  logic [AW-1:0]       addr_wdata,
    input  logic [AW-1:0]       chk_word,
    input  acc_kind_e           chk_kind,
    output region_cfg_t         cfg_q,
    output logic [AW-1:0]       addr_q,
    output logic                hit,
    output logic                allow
);

    logic [AW-1:0] span_mask;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (cfg_wr && !cfg_q.locked)
            cfg_q <= cfg_merge(cfg_q, cfg_wbyte);
    end

    // address register carries no reset value
    always_ff @(posedge clk) begin
        if (addr_wr && !cfg_q.locked)
            addr_q <= addr_wdata | FORCE_MASK;
    end

    always_comb begin
        // trailing ones plus the first zero above them
        span_mask = addr_q ^ (addr_q + AW'(1));
        hit   = (cfg_q.mode == MODE_POW2) && (((chk_word ^ addr_q) & ~span_mask) == '0);
        allow = cfg_permits(cfg_q, chk_kind);
    end

endmodule

// File: rtl/pmp_prio_select.sv
module pmp_prio_select #(
    parameter int N = 6
) (
    input  logic [N-1:0] hit,
    input  logic [N-1:0] allow,
    input  logic [N-1:0] locked,
    output logic         any_hit,
    output logic         win_allow,
    output logic         win_lock
);

    always_comb begin
        any_hit   = 1'b0;
        win_allow = 1'b0;
        win_lock  = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any_hit   = 1'b1;
                win_allow = allow[i];
                win_lock  = locked[i];
            end
        end
    end

endmodule

// File: rtl/pmp_napot_checker.sv
module pmp_napot_checker
    import pmp_napot_pkg::*;
#(
    parameter int          NUM_REGIONS   = 6,
    parameter int          ADDR_W        = 32,
    parameter int          MIN_GRAN_LOG2 = 3,
    parameter logic [11:0] CFG_BASE      = 12'h3A0,
    parameter logic [11:0] ADDR_BASE     = 12'h3B0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_we,
    input  logic [11:0]       csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    input  logic              chk_valid,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [1:0]        chk_acc,
    input  logic              chk_user,
    output logic              res_valid,
    output logic              res_fault
);

    localparam int            FORCE_ONES = MIN_GRAN_LOG2 - 3;
    localparam logic [ADDR_W-1:0] FORCE_MASK = (ADDR_W'(1) << FORCE_ONES) - ADDR_W'(1);

    region_cfg_t              cfg_q  [NUM_REGIONS];
    logic [ADDR_W-1:0]        addr_q [NUM_REGIONS];
    logic [NUM_REGIONS-1:0]   hit_vec, allow_vec, lock_vec;
    logic [NUM_REGIONS-1:0]   cfg_wr, addr_wr;
    logic [ADDR_W-1:0]        chk_word;
    logic                     any_hit, win_allow, win_lock, fault_c;

    assign chk_word = chk_addr >> 2;

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        assign cfg_wr[r]  = csr_we && (csr_addr == CFG_BASE + 12'(r / ENTRIES_PER_CSR));
        assign addr_wr[r] = csr_we && (csr_addr == ADDR_BASE + 12'(r));

        pmp_region_slot #(
            .AW         (ADDR_W),
            .FORCE_MASK (FORCE_MASK)
        ) slot_i (
            .clk        (clk),
            .rst        (rst),
            .cfg_wr     (cfg_wr[r]),
            .cfg_wbyte  (csr_wdata[ENTRY_W*(r % ENTRIES_PER_CSR) +: ENTRY_W]),
            .addr_wr    (addr_wr[r]),
            .addr_wdata (csr_wdata[ADDR_W-1:0]),
            .chk_word   (chk_word),
            .chk_kind   (acc_kind_e'(chk_acc)),
            .cfg_q      (cfg_q[r]),
            .addr_q     (addr_q[r]),
            .hit        (hit_vec[r]),
            .allow      (allow_vec[r])
        );

        assign lock_vec[r] = cfg_q[r].locked;
    end

    pmp_prio_select #(.N(NUM_REGIONS)) prio_i (
        .hit       (hit_vec),
        .allow     (allow_vec),
        .locked    (lock_vec),
        .any_hit   (any_hit),
        .win_allow (win_allow),
        .win_lock  (win_lock)
    );

    // read mux: anything not decoded to an existing region reads zero
    always_comb begin
        csr_rdata = '0;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (csr_addr == CFG_BASE + 12'(r / ENTRIES_PER_CSR))
                csr_rdata[ENTRY_W*(r % ENTRIES_PER_CSR) +: ENTRY_W] = cfg_q[r];
            if (csr_addr == ADDR_BASE + 12'(r))
                csr_rdata = CSR_W'(addr_q[r]);
        end
    end

    always_comb begin
        if (any_hit)
            fault_c = (chk_user || win_lock) && !win_allow;
        else
            fault_c = chk_user;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_fault <= 1'b0;
        end else begin
            res_valid <= chk_valid;
            if (chk_valid)
                res_fault <= fault_c;
        end
    end

endmodule

// File: rtl/pmp_napot_checker_sva.sv
module pmp_napot_checker_sva #(
    parameter int          N         = 6,
    parameter logic [11:0] CFG_BASE  = 12'h3A0,
    parameter logic [11:0] ADDR_BASE = 12'h3B0
) (
    input logic         clk,
    input logic         rst,
    input logic [11:0]  csr_addr,
    input logic [31:0]  csr_rdata,
    input logic         chk_valid,
    input logic         chk_user,
    input logic         res_valid,
    input logic         res_fault,
    input logic         any_hit,
    input logic [N-1:0] lock_vec
);

    localparam int NCFG = (N + 3) / 4;

    logic cfg_sel, unused_csr;

    always_comb begin
        cfg_sel    = 1'b0;
        unused_csr = 1'b0;
        for (int k = 0; k < 16; k++) begin
            if (csr_addr == CFG_BASE + 12'(k)) begin
                cfg_sel = 1'b1;
                if (k >= NCFG) unused_csr = 1'b1;
            end
        end
        for (int k = N; k < 64; k++)
            if (csr_addr == ADDR_BASE + 12'(k)) unused_csr = 1'b1;
    end

    function automatic logic odd_mode(logic [31:0] v);
        logic bad;
        bad = 1'b0;
        for (int b = 0; b < 4; b++)
            if (v[8*b+3] != v[8*b+4]) bad = 1'b1;
        return bad;
    endfunction

    AST_RESERVED_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        cfg_sel |-> ((csr_rdata & 32'h6060_6060) == 32'h0)); // R2

    AST_NO_ODD_MODE: assert property (@(posedge clk) disable iff (rst)
        cfg_sel |-> !odd_mode(csr_rdata)); // R3

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        ((lock_vec & $past(lock_vec)) == $past(lock_vec))); // R4

    AST_ABSENT_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        unused_csr |-> (csr_rdata == 32'h0)); // R6

    AST_USER_UNCOVERED_FAULT: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(chk_user) && !$past(any_hit)) |-> res_fault); // R9

    AST_ONE_CYCLE_RESULT: assert property (@(posedge clk) disable iff (rst)
        res_valid == ($past(chk_valid) && !$past(rst))); // R11

endmodule

bind pmp_napot_checker pmp_napot_checker_sva #(
    .N         (NUM_REGIONS),
    .CFG_BASE  (CFG_BASE),
    .ADDR_BASE (ADDR_BASE)
) sva_i (
    .clk       (clk),
    .rst       (rst),
    .csr_addr  (csr_addr),
    .csr_rdata (csr_rdata),
    .chk_valid (chk_valid),
    .chk_user  (chk_user),
    .res_valid (res_valid),
    .res_fault (res_fault),
    .any_hit   (any_hit),
    .lock_vec  (lock_vec)
);

// File: tb/pmp_napot_checker_tb_top.sv
module pmp_napot_checker_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        chk_valid = 1'b0;
    logic [31:0] chk_addr = '0;
    logic [1:0]  chk_acc = '0;
    logic        chk_user = 1'b0;
    logic        res_valid, res_fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic  exp_q[$];
    string tag_q[$];

    localparam logic [1:0] RD = 2'b00, WR = 2'b01, EX = 2'b10;

    always #5 clk = ~clk;

    pmp_napot_checker dut_i (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .chk_valid(chk_valid),
        .chk_addr(chk_addr), .chk_acc(chk_acc), .chk_user(chk_user),
        .res_valid(res_valid), .res_fault(res_fault)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_expect(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        csr_addr = a;
        #1 check(tag, csr_rdata, exp);
    endtask

    // driver: present one access and push the expected decision
    task automatic access(input logic [31:0] a, input logic [1:0] k, input logic u,
                          input logic exp, input string tag);
        @(negedge clk);
        chk_valid = 1'b1; chk_addr = a; chk_acc = k; chk_user = u;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        chk_valid = 1'b0;
        #1 check("R11 result one cycle later", 32'(res_valid), 32'd1);
    endtask

    // monitor: compare each produced decision with the queue head
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected result", 32'd1, 32'd0);
            end else begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, 32'(res_fault), 32'(e));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        csr_expect(12'h3A0, 32'h0, "R1 cfg csr0 after reset");
        csr_expect(12'h3A1, 32'h0, "R1 cfg csr1 after reset");
        check("R1 res_valid after reset", 32'(res_valid), 32'd0);
        access(32'h0000_0000, RD, 1'b1, 1'b1, "R9 user no match");
        access(32'h0000_0000, RD, 1'b0, 1'b0, "R10 machine no match");

        // region 0: 8 bytes at 0x1000, read only, reserved bits attempted
        csr_write(12'h3B0, 32'h0000_0400);
        csr_write(12'h3A0, 32'h0000_0079);
        csr_expect(12'h3A0, 32'h0000_0019, "R2 reserved bits dropped");
        csr_expect(12'h3B0, 32'h0000_0400, "R5 address readback");
        access(32'h0000_1004, RD, 1'b1, 1'b0, "R7 inside 8-byte window");
        access(32'h0000_1004, WR, 1'b1, 1'b1, "R9 write not permitted");
        access(32'h0000_1008, RD, 1'b1, 1'b1, "R7 one past upper edge");
        access(32'h0000_0FFC, RD, 1'b1, 1'b1, "R7 below lower edge");
        access(32'h0000_1000, EX, 1'b1, 1'b1, "R9 fetch not permitted");
        access(32'h0000_1000, 2'b11, 1'b1, 1'b1, "R9 kind 11 denied");

        // regions 1 (64 B RWX) and 2 (4 KB R) overlapping at 0x2000
        csr_write(12'h3B1, 32'h0000_0807);
        csr_write(12'h3B2, 32'h0000_09FF);
        csr_write(12'h3B3, 32'h0000_1400);
        csr_write(12'h3A0, 32'h0019_1F19);
        csr_expect(12'h3B1, 32'h0000_0807, "R5 region1 address readback");
        access(32'h0000_2010, WR, 1'b1, 1'b0, "R8 nested region wins");
        access(32'h0000_2040, WR, 1'b1, 1'b1, "R8 outer region only");
        access(32'h0000_203C, EX, 1'b1, 1'b0, "R7 64-byte window top");
        access(32'h0000_2040, EX, 1'b1, 1'b1, "R8 fetch in outer region");
        access(32'h0000_2FFC, RD, 1'b1, 1'b0, "R7 4KB window top");
        access(32'h0000_3000, RD, 1'b1, 1'b1, "R7 past 4KB window");

        // odd mode requests: region 0 keeps 11, region 3 keeps 00
        csr_write(12'h3A0, 32'h1719_1F0B);
        csr_expect(12'h3A0, 32'h0719_1F1B, "R3 odd mode keeps previous");
        access(32'h0000_5000, RD, 1'b1, 1'b1, "R12 off region no match");
        access(32'h0000_1000, WR, 1'b1, 1'b0, "R3 permissions still written");
        access(32'h0000_1000, EX, 1'b0, 1'b0, "R10 machine vs unlocked region");

        // region 4: locked, read only, 8 bytes at 0x1800
        csr_write(12'h3B4, 32'h0000_0600);
        csr_write(12'h3A1, 32'h0000_0099);
        csr_expect(12'h3A1, 32'h0000_0099, "R2 lock field set");
        access(32'h0000_1800, WR, 1'b0, 1'b1, "R10 machine vs locked denies");
        access(32'h0000_1800, RD, 1'b0, 1'b0, "R10 machine vs locked permits");
        access(32'h0000_1800, RD, 1'b1, 1'b0, "R9 user read permitted");

        csr_write(12'h3B5, 32'hFFFF_FFFF);
        csr_write(12'h3B4, 32'h0000_1234);
        csr_expect(12'h3B4, 32'h0000_0600, "R4 locked address unchanged");
        csr_write(12'h3A1, 32'hFFFF_191F);
        csr_expect(12'h3A1, 32'h0000_1999, "R4 R6 lock kept, absent bytes zero");
        csr_write(12'h3B6, 32'h0000_0055);
        csr_expect(12'h3B6, 32'h0, "R6 absent address csr");
        csr_expect(12'h3A2, 32'h0, "R6 absent cfg csr");

        access(32'h0000_3000, RD, 1'b1, 1'b0, "R7 all-ones covers all");
        access(32'h0000_3000, WR, 1'b1, 1'b1, "R9 all-ones read only");
        access(32'h0000_1800, WR, 1'b1, 1'b1, "R8 region4 before region5");
        access(32'h0000_1800, WR, 1'b0, 1'b1, "R10 locked still enforced");
        access(32'h0000_3000, WR, 1'b0, 1'b0, "R10 machine vs unlocked");

        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        csr_expect(12'h3A1, 32'h0, "R4 reset clears lock");
        csr_expect(12'h3A0, 32'h0, "R1 cfg cleared by reset");

        repeat (3) @(negedge clk);
        check("R11 all results delivered", 32'(exp_q.size()), 32'd0);
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule